// File: doc/BRIEF.md
# Paged Configuration Register Port over SPI

This block is a serial slave that lets a host processor read and write a banked space of byte-wide configuration locations. The host drives an SPI link with the clock idling low; the block oversamples the link in its own system clock domain. Each page holds 128 locations that a 7-bit address reaches. Location 0 of every page holds the page pointer, so a single address width covers a control page and several coefficient pages.

The control page (page 0) holds a software reset location, a bank of plain control bytes, live status bytes and sticky flag bytes that clear once the host has read them. The pages from 1 up to the configured count hold coefficient bytes. Every other location is reserved. The control bytes go to the rest of the chip as a flat vector. The coefficient bytes go out through a combinational lookup port. A single-cycle pulse marks a software reset.

A transfer opens with a command byte: the upper seven bits give the start address and bit 0 gives the direction, 1 for read. The data bytes that follow go to or come from consecutive locations.

Top module: `paged_reg_spi`

## Requirements
- R1: While `rst_n` is low at a clock edge, the page pointer, every control byte, every sticky byte and every coefficient byte clear to 0x00, and `soft_rst_pulse` and `spi_miso` go low.
- R2: In a transfer the block samples `spi_mosi` on rising `spi_sclk` and changes `spi_miso` only after falling `spi_sclk`, most significant bit first. `spi_miso` is low while `spi_ss_n` is high and during the command byte.
- R3: The first byte after `spi_ss_n` falls is the command, with address in bits 7:1 and bit 0 = 1 for read. Each following data byte uses the next address, and the address wraps from 127 to 0.
- R4: Location 0 on any page reads and writes the full 8-bit page pointer. A new pointer applies from the next byte of the same transfer and stays in force across transfers.
- R5: Page 0 locations 2 to 9 are plain storage. Location 2+k appears on `ctrl_out[8k+7:8k]`.
- R6: Writing a byte with bit 0 set to page 0 location 1 gives one high cycle on `soft_rst_pulse` and returns every location to its reset value. With bit 0 clear the write has no effect. Location 1 reads 0x00.
- R7: On pages 1 to 2, locations 8 to 127 are storage. They read back over MISO, and `coef_rd_data` shows the byte at `coef_rd_page`/`coef_rd_loc`.
- R8: Reserved locations ignore writes and read 0x00. These are: page 0 locations 10-31, 34-39 and 42-127; locations 1-7 of pages 1-2; and every location except 0 on pages 3 and above.
- R9: Page 0 locations 32 and 33 return `status_flags[7:0]` and `status_flags[15:8]` as sampled when the byte is fetched. Writes to them are ignored.
- R10: Page 0 locations 40 and 41 hold sticky flags. A high bit of `sticky_set[7:0]`/`[15:8]` sets the bit. A bit clears only when it was 1 in a read byte whose last bit the host has clocked in. Bits set after the byte was fetched survive, and host writes are ignored.
- R11: Raising `spi_ss_n` mid-byte discards the partial byte without a write. The next transfer starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI link |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| status_flags | input | 16 | Live status bytes, one per status location |
| sticky_set | input | 16 | Per-bit set strobes for the sticky flag bytes |
| coef_rd_page | input | 8 | Page number for the coefficient lookup port |
| coef_rd_loc | input | 7 | Location for the coefficient lookup port |
| page_sel | output | 8 | Current page pointer |
| ctrl_out | output | 64 | Control bytes, byte k from location 2+k |
| coef_rd_data | output | 8 | Coefficient byte at the lookup address, 0x00 if reserved |
| soft_rst_pulse | output | 1 | One-cycle pulse after a software reset write |

## Verification
Every storage location on both coefficient pages is written in single long bursts with a value computed from page and location, then read back both over MISO and through the lookup port. A wrong page or offset mapping therefore shows up as a mismatched byte. Control bytes are tested with single-byte and burst transfers, which separates per-transfer addressing from auto-increment. A burst that crosses location 127 into the page pointer checks the address wrap and that a page change takes effect in the same transfer. The sticky flags are tested with three patterns. In the first, a byte is read and then the transfer is abandoned with the next byte only prefetched. In the second, a flag is raised between fetch and shift-out. In the third, a flag is read twice. These tell clear-on-delivery apart from clear-on-fetch.

// File: rtl/prs_pkg.sv
// Package: shared constants and types for the paged register SPI slave.
// Assumes byte-wide locations and 128 locations per page.
package prs_pkg;
    localparam int BYTE_W     = 8;
    localparam int LOC_W      = 7;
    localparam int BIT_CNT_W  = $clog2(BYTE_W);
    localparam int PAGE_LOCS  = 1 << LOC_W;
    localparam int COEF_FIRST = 8;
    localparam int COEF_LOCS  = PAGE_LOCS - COEF_FIRST;
    localparam int LOC_PAGE   = 0;
    localparam int LOC_SWRST  = 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LOC_W-1:0]  loc_t;
endpackage

// File: rtl/prs_spi_shifter.sv
// SPI shifter: synchronises the host link into clk, frames bytes on rising
// SCLK (clock idle low), shifts MISO out on falling SCLK, MSB first.
// Assumes each SCLK half period spans at least SYNC_STAGES+3 clk cycles.
module prs_spi_shifter
    import prs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk,
    input  logic  ss_n,
    input  logic  mosi,
    output logic  miso,
    output logic  xfer_active,
    output logic  byte_done,
    output byte_t rx_byte,
    input  logic  ld_en,
    input  byte_t ld_data
);
    logic [SYNC_STAGES:0]   sclk_pipe;
    logic [SYNC_STAGES-1:0] ss_pipe;
    logic [SYNC_STAGES-1:0] mosi_pipe;
    logic                   sclk_s, sclk_prev, mosi_s, active;
    logic                   rise, fall;
    logic [BIT_CNT_W-1:0]   bit_cnt;
    byte_t                  rx_sr, tx_sr;
    logic                   miso_q;

    // Purpose: bring the asynchronous link signals into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            ss_pipe   <= '1;
            mosi_pipe <= '0;
        end else begin
            sclk_pipe <= {sclk_pipe[SYNC_STAGES-1:0], sclk};
            ss_pipe   <= {ss_pipe[SYNC_STAGES-2:0], ss_n};
            mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi};
        end
    end

    assign sclk_s    = sclk_pipe[SYNC_STAGES-1];
    assign sclk_prev = sclk_pipe[SYNC_STAGES];
    assign mosi_s    = mosi_pipe[SYNC_STAGES-1];
    assign active    = ~ss_pipe[SYNC_STAGES-1];
    assign rise      = sclk_s & ~sclk_prev;
    assign fall      = ~sclk_s & sclk_prev;

    // Purpose: shift bits in and out; deselect drops any partial byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            miso_q    <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sr   <= {rx_sr[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sr[BYTE_W-2:0], mosi_s};
                end
            end
            if (fall) begin
                miso_q <= tx_sr[BYTE_W-1];
                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
            if (ld_en) tx_sr <= ld_data;
        end
    end

    assign miso        = miso_q;
    assign xfer_active = active;

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !miso_q); // R2
    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done); // R3
    AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> (bit_cnt == '0)); // R3
endmodule

// File: rtl/prs_txn_seq.sv
// Transfer sequencer: decodes the command byte, keeps the running address,
// issues writes and read fetches. Assumes byte_done pulses one cycle a byte.
module prs_txn_seq
    import prs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  xfer_active,
    input  logic  byte_done,
    input  byte_t rx_byte,
    output logic  ld_en,
    output byte_t ld_data,
    output loc_t  rd_addr,
    input  byte_t rd_data,
    output logic  rd_fetch,
    output logic  rd_commit,
    output logic  wr_en,
    output loc_t  wr_addr,
    output byte_t wr_data
);
    logic cmd_phase, read_q;
    loc_t addr_q;
    logic is_cmd, is_data;

    // Purpose: classify the finished byte and derive read and write strobes.
    always_comb begin
        is_cmd    = byte_done & cmd_phase;
        is_data   = byte_done & ~cmd_phase;
        rd_addr   = cmd_phase ? rx_byte[BYTE_W-1:1] : addr_q + 1'b1;
        rd_fetch  = (is_cmd & rx_byte[0]) | (is_data & read_q);
        rd_commit = is_data & read_q;
        wr_en     = is_data & ~read_q;
        wr_addr   = addr_q;
        wr_data   = rx_byte;
        ld_en     = rd_fetch;
        ld_data   = rd_data;
    end

    // Purpose: track command phase, direction and running address.
    always_ff @(posedge clk) begin
        if (!rst_n || !xfer_active) begin
            cmd_phase <= 1'b1;
            read_q    <= 1'b0;
            addr_q    <= '0;
        end else if (is_cmd) begin
            cmd_phase <= 1'b0;
            read_q    <= rx_byte[0];
            addr_q    <= rx_byte[BYTE_W-1:1];
        end else if (is_data) begin
            addr_q    <= addr_q + 1'b1;
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !cmd_phase && xfer_active) |=> (addr_q == $past(addr_q) + 1'b1)); // R3
endmodule

// File: rtl/prs_reg_bank.sv
// Register bank: page pointer, control bytes, live status, sticky flags and
// coefficient pages with reserved-location decoding and software reset.
// Assumes NUM_PAGES >= 2 and location ranges that do not overlap.
module prs_reg_bank
    import prs_pkg::*;
#(
    parameter int NUM_PAGES   = 3,
    parameter int CTRL_REGS   = 8,
    parameter int CTRL_BASE   = 2,
    parameter int STAT_REGS   = 2,
    parameter int STAT_BASE   = 32,
    parameter int STICKY_REGS = 2,
    parameter int STICKY_BASE = 40
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        xfer_active,
    input  loc_t                        rd_addr,
    output byte_t                       rd_data,
    input  logic                        rd_fetch,
    input  logic                        rd_commit,
    input  logic                        wr_en,
    input  loc_t                        wr_addr,
    input  byte_t                       wr_data,
    input  logic [STAT_REGS*BYTE_W-1:0]   status_flags,
    input  logic [STICKY_REGS*BYTE_W-1:0] sticky_set,
    input  byte_t                       coef_rd_page,
    input  loc_t                        coef_rd_loc,
    output byte_t                       page_sel,
    output logic [CTRL_REGS*BYTE_W-1:0]   ctrl_out,
    output byte_t                       coef_rd_data,
    output logic                        soft_rst_pulse
);
    localparam int COEF_PAGES = NUM_PAGES - 1;
    localparam int CP_W = (COEF_PAGES > 1) ? $clog2(COEF_PAGES) : 1;
    localparam int CT_W = (CTRL_REGS > 1) ? $clog2(CTRL_REGS) : 1;
    localparam int SK_W = (STICKY_REGS > 1) ? $clog2(STICKY_REGS) : 1;

    byte_t page_q;
    byte_t ctrl_q   [CTRL_REGS];
    byte_t sticky_q [STICKY_REGS];
    byte_t coef_q   [COEF_PAGES][COEF_LOCS];
    logic [STICKY_REGS*BYTE_W-1:0] sticky_flat;

    logic            on_page0, on_coef;
    logic            wr_ctrl_hit, wr_swrst, sw_rst, rd_sticky_hit;
    logic [CT_W-1:0] wr_ctrl_idx;
    logic [SK_W-1:0] rd_sticky_idx, pend_idx;
    logic            pend_valid;
    byte_t           pend_mask;

    assign on_page0 = (page_q == 8'd0);
    assign on_coef  = (page_q != 8'd0) && (page_q < 8'(NUM_PAGES));

    // Purpose: decode the read address on the current page into a byte.
    always_comb begin
        rd_data       = '0;
        rd_sticky_hit = 1'b0;
        rd_sticky_idx = '0;
        if (rd_addr == LOC_W'(LOC_PAGE)) begin
            rd_data = page_q;
        end else if (on_page0) begin
            for (int k = 0; k < CTRL_REGS; k++)
                if (rd_addr == LOC_W'(CTRL_BASE + k)) rd_data = ctrl_q[k];
            for (int k = 0; k < STAT_REGS; k++)
                if (rd_addr == LOC_W'(STAT_BASE + k)) rd_data = status_flags[BYTE_W*k +: BYTE_W];
            for (int k = 0; k < STICKY_REGS; k++)
                if (rd_addr == LOC_W'(STICKY_BASE + k)) begin
                    rd_data       = sticky_q[k];
                    rd_sticky_hit = 1'b1;
                    rd_sticky_idx = SK_W'(k);
                end
        end else if (on_coef && rd_addr >= LOC_W'(COEF_FIRST)) begin
            rd_data = coef_q[CP_W'(page_q - 8'd1)][rd_addr - LOC_W'(COEF_FIRST)];
        end
    end

    // Purpose: decode the write address into control and reset hits.
    always_comb begin
        wr_ctrl_hit = 1'b0;
        wr_ctrl_idx = '0;
        for (int k = 0; k < CTRL_REGS; k++)
            if (wr_addr == LOC_W'(CTRL_BASE + k)) begin
                wr_ctrl_hit = on_page0;
                wr_ctrl_idx = CT_W'(k);
            end
        wr_swrst = on_page0 && (wr_addr == LOC_W'(LOC_SWRST)) && wr_data[0];
        sw_rst   = wr_en && wr_swrst;
    end

    // Purpose: hold the page pointer, control bytes and coefficient storage.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            page_q <= '0;
            for (int k = 0; k < CTRL_REGS; k++) ctrl_q[k] <= '0;
            for (int p = 0; p < COEF_PAGES; p++)
                for (int l = 0; l < COEF_LOCS; l++) coef_q[p][l] <= '0;
        end else if (wr_en) begin
            if (wr_addr == LOC_W'(LOC_PAGE))
                page_q <= wr_data;
            else if (wr_ctrl_hit)
                ctrl_q[wr_ctrl_idx] <= wr_data;
            else if (on_coef && wr_addr >= LOC_W'(COEF_FIRST))
                coef_q[CP_W'(page_q - 8'd1)][wr_addr - LOC_W'(COEF_FIRST)] <= wr_data;
        end
    end

    // Purpose: set sticky bits, clear only bits delivered to the host.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            for (int k = 0; k < STICKY_REGS; k++) sticky_q[k] <= '0;
            pend_valid <= 1'b0;
            pend_idx   <= '0;
            pend_mask  <= '0;
        end else begin
            for (int k = 0; k < STICKY_REGS; k++)
                sticky_q[k] <= (sticky_q[k] &
                                ~((rd_commit && pend_valid && pend_idx == SK_W'(k)) ? pend_mask : 8'h00))
                               | sticky_set[BYTE_W*k +: BYTE_W];
            if (!xfer_active) begin
                pend_valid <= 1'b0;
            end else if (rd_fetch) begin
                pend_valid <= rd_sticky_hit;
                pend_idx   <= rd_sticky_idx;
                pend_mask  <= rd_data;
            end else if (rd_commit) begin
                pend_valid <= 1'b0;
            end
        end
    end

    // Purpose: flag a software reset for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst_pulse <= 1'b0;
        else        soft_rst_pulse <= sw_rst;
    end

    // Purpose: coefficient lookup port for the consumers of the stored bytes.
    always_comb begin
        coef_rd_data = '0;
        if (coef_rd_page != 8'd0 && coef_rd_page < 8'(NUM_PAGES) && coef_rd_loc >= LOC_W'(COEF_FIRST))
            coef_rd_data = coef_q[CP_W'(coef_rd_page - 8'd1)][coef_rd_loc - LOC_W'(COEF_FIRST)];
    end

    for (genvar g = 0; g < CTRL_REGS; g++) begin : g_ctrl
        assign ctrl_out[BYTE_W*g +: BYTE_W] = ctrl_q[g];
    end
    for (genvar g = 0; g < STICKY_REGS; g++) begin : g_stk
        assign sticky_flat[BYTE_W*g +: BYTE_W] = sticky_q[g];
    end
    assign page_sel = page_q;

    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> !soft_rst_pulse); // R6
    AST_SRST_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> (page_q == 8'd0)); // R6
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(page_q)); // R4
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_commit && !wr_en) |=> ((sticky_flat & $past(sticky_flat)) == $past(sticky_flat))); // R10
endmodule

// File: rtl/paged_reg_spi.sv
// Top: SPI slave giving a host access to a paged byte register space.
// Assumes spi_sclk half periods of at least SYNC_STAGES+3 clk cycles.
module paged_reg_spi
    import prs_pkg::*;
#(
    parameter int NUM_PAGES   = 3,
    parameter int CTRL_REGS   = 8,
    parameter int CTRL_BASE   = 2,
    parameter int STAT_REGS   = 2,
    parameter int STAT_BASE   = 32,
    parameter int STICKY_REGS = 2,
    parameter int STICKY_BASE = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spi_sclk,
    input  logic                          spi_ss_n,
    input  logic                          spi_mosi,
    output logic                          spi_miso,
    input  logic [STAT_REGS*8-1:0]        status_flags,
    input  logic [STICKY_REGS*8-1:0]      sticky_set,
    input  logic [7:0]                    coef_rd_page,
    input  logic [6:0]                    coef_rd_loc,
    output logic [7:0]                    page_sel,
    output logic [CTRL_REGS*8-1:0]        ctrl_out,
    output logic [7:0]                    coef_rd_data,
    output logic                          soft_rst_pulse
);
    logic  xfer_active, byte_done, ld_en, rd_fetch, rd_commit, wr_en;
    byte_t rx_byte, ld_data, rd_data, wr_data;
    loc_t  rd_addr, wr_addr;

    prs_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .ss_n(spi_ss_n),
        .mosi(spi_mosi), .miso(spi_miso), .xfer_active(xfer_active),
        .byte_done(byte_done), .rx_byte(rx_byte), .ld_en(ld_en), .ld_data(ld_data)
    );

    prs_txn_seq u_seq (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
        .byte_done(byte_done), .rx_byte(rx_byte), .ld_en(ld_en),
        .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_fetch(rd_fetch), .rd_commit(rd_commit), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    prs_reg_bank #(
        .NUM_PAGES(NUM_PAGES), .CTRL_REGS(CTRL_REGS), .CTRL_BASE(CTRL_BASE),
        .STAT_REGS(STAT_REGS), .STAT_BASE(STAT_BASE),
        .STICKY_REGS(STICKY_REGS), .STICKY_BASE(STICKY_BASE)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_fetch(rd_fetch),
        .rd_commit(rd_commit), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .status_flags(status_flags), .sticky_set(sticky_set),
        .coef_rd_page(coef_rd_page), .coef_rd_loc(coef_rd_loc),
        .page_sel(page_sel), .ctrl_out(ctrl_out), .coef_rd_data(coef_rd_data),
        .soft_rst_pulse(soft_rst_pulse)
    );
endmodule

// File: tb/paged_reg_spi_tb.sv
`timescale 1ns/1ps
module paged_reg_spi_tb;
    localparam int HALF = 32;
    localparam int WD_CYCLES = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic [15:0] status_flags = 16'hA5C3;
    logic [15:0] sticky_set = '0;
    logic [7:0]  coef_rd_page = '0;
    logic [6:0]  coef_rd_loc = '0;
    logic [7:0]  page_sel, coef_rd_data;
    logic [63:0] ctrl_out;
    logic        soft_rst_pulse;
    int          nchk = 0, nfail = 0, npulse = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    paged_reg_spi u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_ss_n(ss_n),
        .spi_mosi(mosi), .spi_miso(miso), .status_flags(status_flags),
        .sticky_set(sticky_set), .coef_rd_page(coef_rd_page),
        .coef_rd_loc(coef_rd_loc), .page_sel(page_sel), .ctrl_out(ctrl_out),
        .coef_rd_data(coef_rd_data), .soft_rst_pulse(soft_rst_pulse)
    );

    always @(negedge clk) if (soft_rst_pulse) npulse++;

    function automatic logic [7:0] coef_val(input int p, input int l);
        return 8'((p * 53 + l * 7) ^ 8'h3C);
    endfunction
    function automatic logic [7:0] ctrl_val(input int k);
        return 8'(k * 37 + 5);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sel();
        @(negedge clk); #1;
        ss_n = 1'b0;
        #(HALF);
    endtask
    task automatic desel();
        #(HALF);
        ss_n = 1'b1;
        #(4 * HALF);
    endtask
    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = t[i];
            #(HALF);
            sclk = 1'b1;
            r[i] = miso;
            #(HALF);
            sclk = 1'b0;
        end
    endtask
    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r;
        sel(); xbyte({a, 1'b0}, r); xbyte(d, r); desel();
    endtask
    task automatic rd_reg(input logic [6:0] a, output logic [7:0] d);
        logic [7:0] r;
        sel(); xbyte({a, 1'b1}, r); xbyte(8'h00, d); desel();
    endtask
    task automatic pulse_sticky(input logic [15:0] v);
        @(negedge clk); sticky_set = v;
        @(negedge clk); sticky_set = '0;
    endtask
    task automatic peek_coef(input int p, input int l, output logic [7:0] d);
        coef_rd_page = 8'(p); coef_rd_loc = 7'(l);
        #1 d = coef_rd_data;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk("R1 page", page_sel, 8'h00);
        chk("R1 ctrl", ctrl_out[31:0], 32'h0);
        chk("R1 ctrl hi", ctrl_out[63:32], 32'h0);
        chk("R1 pulse", soft_rst_pulse, 1'b0);
        chk("R1 miso", miso, 1'b0);
        peek_coef(1, 8, d);   chk("R1 coef", d, 8'h00);

        // R2: MISO idle while deselected, low during command byte
        sclk = 1'b1; #(HALF); sclk = 1'b0; #(HALF);
        chk("R2 idle miso", miso, 1'b0);

        // R5: single writes of every control byte, read back both ways
        for (int k = 0; k < 8; k++) wr_reg(7'(2 + k), ctrl_val(k));
        for (int k = 0; k < 8; k++) begin
            sel(); xbyte({7'(2 + k), 1'b1}, r); xbyte(8'h00, d); desel();
            chk("R2 cmd-phase miso", r, 8'h00);
            chk("R5 spi read", d, ctrl_val(k));
            chk("R5 ctrl_out", ctrl_out[8*k +: 8], ctrl_val(k));
        end

        // R3: burst write 2..5 then burst read 2..9
        sel(); xbyte({7'd2, 1'b0}, r);
        for (int k = 0; k < 4; k++) xbyte(8'(8'hA0 + k), r);
        desel();
        sel(); xbyte({7'd2, 1'b1}, r);
        for (int k = 0; k < 8; k++) begin
            xbyte(8'h00, d);
            chk("R3 burst read", d, (k < 4) ? 8'(8'hA0 + k) : ctrl_val(k));
        end
        desel();

        // R8 / R6: page 0 reserved 10..31 and reset location 1
        sel(); xbyte({7'd10, 1'b0}, r);
        for (int l = 10; l < 32; l++) xbyte(8'hFF, r);
        desel();
        sel(); xbyte({7'd9, 1'b1}, r);
        xbyte(8'h00, d); chk("R8 neighbour intact", d, ctrl_val(7));
        for (int l = 10; l < 32; l++) begin
            xbyte(8'h00, d); chk("R8 page0 reserved", d, 8'h00);
        end
        desel();
        rd_reg(7'd1, d); chk("R6 reset loc reads 0", d, 8'h00);

        // R9: live status bytes, writes ignored
        rd_reg(7'd32, d); chk("R9 status lo", d, 8'hC3);
        rd_reg(7'd33, d); chk("R9 status hi", d, 8'hA5);
        wr_reg(7'd32, 8'h00);
        status_flags = 16'h1E96;
        rd_reg(7'd32, d); chk("R9 status lo after write", d, 8'h96);
        rd_reg(7'd33, d); chk("R9 status hi new", d, 8'h1E);

        // R10: clear after delivery
        pulse_sticky(16'h0011);
        rd_reg(7'd40, d); chk("R10 first read", d, 8'h11);
        rd_reg(7'd40, d); chk("R10 cleared", d, 8'h00);
        // R10: prefetched but undelivered byte keeps its flags
        pulse_sticky(16'h2400);
        rd_reg(7'd40, d); chk("R10 empty neighbour", d, 8'h00);
        rd_reg(7'd41, d); chk("R10 prefetch not cleared", d, 8'h24);
        rd_reg(7'd41, d); chk("R10 cleared after delivery", d, 8'h00);
        // R10: flag raised between fetch and shift-out survives
        pulse_sticky(16'h0001);
        sel(); xbyte({7'd40, 1'b1}, r);
        pulse_sticky(16'h0080);
        xbyte(8'h00, d); chk("R10 fetched value", d, 8'h01);
        xbyte(8'h00, d); chk("R10 next loc", d, 8'h00);
        desel();
        rd_reg(7'd40, d); chk("R10 late set survives", d, 8'h80);
        wr_reg(7'd40, 8'hFF);
        rd_reg(7'd40, d); chk("R10 write ignored", d, 8'h00);

        // R7: full sweep of both coefficient pages
        for (int p = 1; p <= 2; p++) begin
            wr_reg(7'd0, 8'(p));
            sel(); xbyte({7'd8, 1'b0}, r);
            for (int l = 8; l < 128; l++) xbyte(coef_val(p, l), r);
            desel();
        end
        for (int p = 1; p <= 2; p++) begin
            wr_reg(7'd0, 8'(p));
            sel(); xbyte({7'd8, 1'b1}, r);
            for (int l = 8; l < 128; l++) begin
                xbyte(8'h00, d); chk("R7 spi readback", d, coef_val(p, l));
            end
            desel();
            for (int l = 8; l < 128; l++) begin
                peek_coef(p, l, d); chk("R7 lookup port", d, coef_val(p, l));
            end
        end

        // R8: coefficient reserved 1..7 and pages beyond the count
        wr_reg(7'd0, 8'd1);
        sel(); xbyte({7'd1, 1'b0}, r);
        for (int l = 1; l < 8; l++) xbyte(8'hFF, r);
        desel();
        sel(); xbyte({7'd1, 1'b1}, r);
        for (int l = 1; l < 8; l++) begin
            xbyte(8'h00, d); chk("R8 coef reserved", d, 8'h00);
        end
        xbyte(8'h00, d); chk("R8 first data intact", d, coef_val(1, 8));
        desel();
        wr_reg(7'd0, 8'd3);
        sel(); xbyte({7'd8, 1'b0}, r);
        for (int l = 8; l < 16; l++) xbyte(8'h5A, r);
        desel();
        rd_reg(7'd8, d); chk("R8 out-of-range page", d, 8'h00);
        rd_reg(7'd0, d); chk("R4 page pointer readback", d, 8'h03);
        peek_coef(2, 8, d); chk("R8 no alias into page 2", d, coef_val(2, 8));

        // R3 / R4: wrap 127 -> 0 changes page mid-transfer
        wr_reg(7'd0, 8'd1);
        sel(); xbyte({7'd127, 1'b0}, r);
        xbyte(8'h5A, r); xbyte(8'h02, r); xbyte(8'h99, r);
        desel();
        peek_coef(1, 127, d); chk("R3 last location", d, 8'h5A);
        chk("R3 wrap into page pointer", page_sel, 8'h02);
        rd_reg(7'd1, d); chk("R4 loc1 on new page reserved", d, 8'h00);
        peek_coef(2, 127, d); chk("R4 new page untouched", d, coef_val(2, 127));
        rd_reg(7'd0, d); chk("R4 page persists", d, 8'h02);

        // R11: aborted bytes
        wr_reg(7'd0, 8'd0);
        sel(); xbyte({7'd3, 1'b0}, r);
        for (int i = 0; i < 5; i++) begin
            mosi = 1'b1; #(HALF); sclk = 1'b1; #(HALF); sclk = 1'b0;
        end
        desel();
        chk("R11 partial byte dropped", ctrl_out[15:8], 8'hA1);
        sel();
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b0; #(HALF); sclk = 1'b1; #(HALF); sclk = 1'b0;
        end
        desel();
        wr_reg(7'd3, 8'h77);
        chk("R11 fresh command", ctrl_out[15:8], 8'h77);

        // R6: software reset
        wr_reg(7'd0, 8'd1);
        wr_reg(7'd1, 8'h01);
        chk("R6 no reset off page 0", npulse, 0);
        chk("R6 ctrl intact", ctrl_out[15:8], 8'h77);
        wr_reg(7'd0, 8'd0);
        wr_reg(7'd1, 8'hFE);
        chk("R6 bit0 clear no reset", npulse, 0);
        chk("R6 ctrl still set", ctrl_out[15:8], 8'h77);
        wr_reg(7'd1, 8'h01);
        chk("R6 one pulse", npulse, 1);
        chk("R6 ctrl cleared", ctrl_out[31:0], 32'h0);
        chk("R6 page cleared", page_sel, 8'h00);
        peek_coef(2, 50, d); chk("R6 coef cleared", d, 8'h00);
        peek_coef(1, 127, d); chk("R6 coef cleared 2", d, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule